// File: doc/BRIEF.md
# Window Mapping Request Validator

This block takes one request that asks to expose part of a fixed on-chip region through the host address window. It checks the request against a set of rules and then produces the two configuration words that program the window. The request names a window type, a window id, the host-side address, an offset into the region and a window size. Two region descriptors are fixed by parameters. One describes the flash region and the other the reserved memory region, and each has a base and a size.

A request is presented with a one-cycle strobe. Exactly two clock edges later the block raises a one-cycle done pulse with a 3-bit result code. When the request passes, the pulse also carries the translate word and the mask word. The same strobe can instead carry a size query, which returns the size of the memory region. Only one request is in flight at a time, and a strobe that arrives while the block is busy is dropped.

Top module: `map_req_check`

## Requirements
- R1: For a map request, type 1 selects the flash region and type 2 selects the memory region. Any other type ends with code 1. The window id has no effect on a map request.
- R2: A map request whose size or offset has any of bits [15:0] set ends with code 2.
- R3: A map request whose offset ANDed with (size-1) is nonzero ends with code 3.
- R4: A map request ends with code 4 if offset+size carries out of 32 bits, or if the 32-bit sum exceeds the selected region size. The carry test is made first.
- R5: A map request with size 0 ends with code 5. A size that is not a power of two ends with code 6.
- R6: When code 0 is returned for a map request, word0_o equals (region base + offset) OR (host address >> 16).
- R7: When code 0 is returned for a map request, word1_o equals NOT(size-1) OR ((size >> 16) - 1).
- R8: A size query passes with code 0 and returns the memory region size on size_o only when the type is 2 and the id is 0. Otherwise it ends with code 1.
- R9: The checks apply in the order type, low bits, alignment, range, size. The code reported is that of the first check that fails.
- R10: done_o is high for exactly one cycle, two clock edges after an accepted strobe. busy_o is high for the one cycle in between. A strobe seen while busy_o is high is ignored.
- R11: After reset, done_o, busy_o, err_o, word0_o, word1_o and size_o are all zero.
- R12: With a nonzero code, word0_o, word1_o and size_o are zero. After a map request, size_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_query_i | input | 1 | 1 = size query, 0 = map request |
| win_type_i | input | 8 | Window type (1 flash, 2 memory) |
| win_id_i | input | 8 | Window id |
| host_addr_i | input | 32 | Host-side window address |
| offset_i | input | 32 | Offset into the region |
| size_i | input | 32 | Window size in bytes |
| busy_o | output | 1 | A request is in flight |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 3 | Result code (0 ok, 1 type/id, 2 low bits, 3 misaligned, 4 range, 5 zero size, 6 not power of two) |
| word0_o | output | 32 | Translate word |
| word1_o | output | 32 | Mask word |
| size_o | output | 32 | Memory region size from a query |

## Verification
Passing maps on both regions, including one that covers the whole region, show that the base is selected correctly and that both word formulas hold. Each rejection is triggered with a stimulus that breaks only the rule under test. One exception is an offset and size pair whose sum wraps to zero. That pair would pass the range bound if the carry were not tested, and it would then be reported as a bad size, so it shows whether the carry check comes first. Requests that break two rules at once show the order of the checks. A second strobe held during the busy cycle shows that such a strobe is dropped.

// File: rtl/map_req_pkg.sv
package map_req_pkg;
  localparam int AW    = 32;
  localparam int LOW_W = 16;
  localparam int TW    = 8;

  localparam logic [TW-1:0] WIN_FLASH = TW'(1);
  localparam logic [TW-1:0] WIN_MEM   = TW'(2);

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_TYPE  = 3'd1,
    ERR_LOW   = 3'd2,
    ERR_ALIGN = 3'd3,
    ERR_RANGE = 3'd4,
    ERR_SIZE  = 3'd5,
    ERR_POW2  = 3'd6
  } err_e;

  typedef struct packed {
    logic          query;
    logic [TW-1:0] wtype;
    logic [TW-1:0] wid;
    logic [AW-1:0] host;
    logic [AW-1:0] off;
    logic [AW-1:0] size;
  } req_t;
endpackage

// File: rtl/map_region_sel.sv
module map_region_sel
  import map_req_pkg::*;
#(
  parameter logic [AW-1:0] FLASH_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] FLASH_SIZE = 32'h0400_0000,
  parameter logic [AW-1:0] MEM_BASE   = 32'h9800_0000,
  parameter logic [AW-1:0] MEM_SIZE   = 32'h0200_0000
) (
  input  logic [TW-1:0] wtype_i,
  output logic          hit_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] lim_o
);
  always_comb begin
    hit_o  = 1'b1;
    base_o = '0;
    lim_o  = '0;
    unique case (wtype_i)
      WIN_FLASH: begin base_o = FLASH_BASE; lim_o = FLASH_SIZE; end
      WIN_MEM:   begin base_o = MEM_BASE;   lim_o = MEM_SIZE;   end
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/map_rule_chk.sv
module map_rule_chk
  import map_req_pkg::*;
(
  input  req_t          req_i,
  input  logic          hit_i,
  input  logic [AW-1:0] lim_i,
  output err_e          err_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << LOW_W) - 64'd1);

  logic [AW:0]   sum;
  logic [AW-1:0] size_m1;
  logic          pow2;

  always_comb begin
    sum     = {1'b0, req_i.off} + {1'b0, req_i.size};
    size_m1 = req_i.size - AW'(1);
    pow2    = (req_i.size & size_m1) == '0;
    err_o   = ERR_NONE;
    if (req_i.query) begin
      if (!(req_i.wtype == WIN_MEM && req_i.wid == '0)) err_o = ERR_TYPE;
    end else if (!hit_i)                                  err_o = ERR_TYPE;
    else if (((req_i.size | req_i.off) & LOW_MASK) != '0) err_o = ERR_LOW;
    else if ((req_i.off & size_m1) != '0)                 err_o = ERR_ALIGN;
    else if (sum[AW] || sum[AW-1:0] > lim_i)              err_o = ERR_RANGE;  // carry first
    else if (req_i.size == '0 || req_i.size > lim_i)      err_o = ERR_SIZE;
    else if (!pow2)                                       err_o = ERR_POW2;
  end
endmodule

// File: rtl/map_word_gen.sv
module map_word_gen
  import map_req_pkg::*;
(
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] host_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] word0_o,
  output logic [AW-1:0] word1_o
);
  always_comb begin
    word0_o = (base_i + off_i) | (host_i >> LOW_W);
    word1_o = ~(size_i - AW'(1)) | ((size_i >> LOW_W) - AW'(1));
  end
endmodule

// File: rtl/map_req_check.sv
module map_req_check
  import map_req_pkg::*;
#(
  parameter logic [AW-1:0] FLASH_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] FLASH_SIZE = 32'h0400_0000,
  parameter logic [AW-1:0] MEM_BASE   = 32'h9800_0000,
  parameter logic [AW-1:0] MEM_SIZE   = 32'h0200_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_query_i,
  input  logic [TW-1:0] win_type_i,
  input  logic [TW-1:0] win_id_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [AW-1:0] offset_i,
  input  logic [AW-1:0] size_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o,
  output logic [AW-1:0] word0_o,
  output logic [AW-1:0] word1_o,
  output logic [AW-1:0] size_o
);
  logic          s1_vld;
  req_t          s1_req;
  logic          hit;
  logic [AW-1:0] base, lim, w0, w1;
  err_e          err;

  // stage 1: capture, drop strobes while occupied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_req <= '0;
    end else begin
      s1_vld <= req_valid_i && !s1_vld;
      if (req_valid_i && !s1_vld)
        s1_req <= '{query: req_query_i, wtype: win_type_i, wid: win_id_i,
                    host: host_addr_i, off: offset_i, size: size_i};
    end
  end

  map_region_sel #(
    .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE),
    .MEM_BASE(MEM_BASE),     .MEM_SIZE(MEM_SIZE)
  ) u_sel (
    .wtype_i(s1_req.wtype), .hit_o(hit), .base_o(base), .lim_o(lim)
  );

  map_rule_chk u_chk (
    .req_i(s1_req), .hit_i(hit), .lim_i(lim), .err_o(err)
  );

  map_word_gen u_gen (
    .base_i(base), .off_i(s1_req.off), .host_i(s1_req.host),
    .size_i(s1_req.size), .word0_o(w0), .word1_o(w1)
  );

  // stage 2: result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      err_o   <= '0;
      word0_o <= '0;
      word1_o <= '0;
      size_o  <= '0;
    end else begin
      done_o <= s1_vld;
      if (s1_vld) begin
        err_o   <= err;
        word0_o <= (err == ERR_NONE && !s1_req.query) ? w0 : '0;
        word1_o <= (err == ERR_NONE && !s1_req.query) ? w1 : '0;
        size_o  <= (err == ERR_NONE &&  s1_req.query) ? MEM_SIZE : '0;
      end
    end
  end

  assign busy_o = s1_vld;
endmodule

// File: rtl/map_req_check_sva.sv
module map_req_check_sva
  import map_req_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    err_o,
  input logic [AW-1:0] word0_o,
  input logic [AW-1:0] word1_o,
  input logic [AW-1:0] size_o
);
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> ##1 done_o);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_BUSY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);  // R10
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o != 3'd0) |-> (word0_o == '0 && word1_o == '0 && size_o == '0));  // R12
  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 3'd0 && size_o == '0) |-> (word1_o[31:16] == ~word1_o[15:0]));  // R7
  AST_QUERY_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o != '0) |-> (err_o == 3'd0 && word0_o == '0));  // R8
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> err_o <= 3'd6);  // R9
endmodule

bind map_req_check map_req_check_sva u_sva (.*);

// File: tb/map_req_check_tb.sv
`timescale 1ns/1ps
module map_req_check_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_query_i = 1'b0;
  logic [7:0]  win_type_i = '0, win_id_i = '0;
  logic [31:0] host_addr_i = '0, offset_i = '0, size_i = '0;
  logic        busy_o, done_o;
  logic [2:0]  err_o;
  logic [31:0] word0_o, word1_o, size_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  localparam logic [31:0] MEM_SZ = 32'h0200_0000;

  always #2.5 clk = ~clk;

  map_req_check u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_query_i(req_query_i),
    .win_type_i(win_type_i), .win_id_i(win_id_i), .host_addr_i(host_addr_i),
    .offset_i(offset_i), .size_i(size_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .word0_o(word0_o), .word1_o(word1_o), .size_o(size_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic q, logic [7:0] t, logic [7:0] id,
                       logic [31:0] h, logic [31:0] o, logic [31:0] s);
    req_valid_i = 1'b1; req_query_i = q; win_type_i = t; win_id_i = id;
    host_addr_i = h; offset_i = o; size_i = s;
  endtask

  task automatic run_req(string tag, logic q, logic [7:0] t, logic [7:0] id,
                         logic [31:0] h, logic [31:0] o, logic [31:0] s,
                         logic [2:0] e_err, logic [31:0] e_w0, logic [31:0] e_w1,
                         logic [31:0] e_sz);
    @(negedge clk);
    drive(q, t, id, h, o, s);
    @(negedge clk);
    req_valid_i = 1'b0;
    check({tag, " R10 busy"}, 32'(busy_o), 32'd1);
    @(negedge clk);
    check({tag, " R10 done"}, 32'(done_o), 32'd1);
    check({tag, " err"},  32'(err_o), 32'(e_err));
    check({tag, " w0"},   word0_o, e_w0);
    check({tag, " w1"},   word1_o, e_w1);
    check({tag, " size"}, size_o, e_sz);
  endtask

  task automatic t_reset;
    check("R11 done", 32'(done_o), 0);
    check("R11 busy", 32'(busy_o), 0);
    check("R11 err",  32'(err_o), 0);
    check("R11 w0",   word0_o, 0);
    check("R11 w1",   word1_o, 0);
    check("R11 size", size_o, 0);
  endtask

  task automatic t_pass;
    run_req("R1 R6 R7 flash", 0, 8'd1, 8'd0, 32'h0E00_0000, 32'h0100_0000, 32'h0100_0000,
            3'd0, 32'h2100_0E00, 32'hFF00_00FF, 0);
    run_req("R1 R6 R7 mem full", 0, 8'd2, 8'd7, 32'h0000_FFFF, 32'h0, 32'h0200_0000,
            3'd0, 32'h9800_0000, 32'hFE00_01FF, 0);
    run_req("R6 R7 min window", 0, 8'd2, 8'd0, 32'hABCD_1234, 32'h0003_0000, 32'h0001_0000,
            3'd0, 32'h9803_ABCD, 32'hFFFF_0000, 0);
  endtask

  task automatic t_reject;
    run_req("R1 type3", 0, 8'd3, 8'd0, 0, 0, 32'h0001_0000, 3'd1, 0, 0, 0);
    run_req("R1 type0", 0, 8'd0, 8'd0, 0, 0, 32'h0001_0000, 3'd1, 0, 0, 0);
    run_req("R2 size low", 0, 8'd1, 8'd0, 0, 0, 32'h0001_8000, 3'd2, 0, 0, 0);
    run_req("R2 off low", 0, 8'd1, 8'd0, 0, 32'h0000_1234, 32'h0001_0000, 3'd2, 0, 0, 0);
    run_req("R3 misaligned", 0, 8'd1, 8'd0, 0, 32'h0001_0000, 32'h0002_0000, 3'd3, 0, 0, 0);
    run_req("R4 over region", 0, 8'd1, 8'd0, 0, 32'h0400_0000, 32'h0400_0000, 3'd4, 0, 0, 0);
    run_req("R4 wrap", 0, 8'd2, 8'd0, 0, 32'h8000_0000, 32'h8000_0000, 3'd4, 0, 0, 0);
    run_req("R5 zero size", 0, 8'd2, 8'd0, 0, 0, 0, 3'd5, 0, 0, 0);
    run_req("R5 non pow2", 0, 8'd1, 8'd0, 0, 0, 32'h0003_0000, 3'd6, 0, 0, 0);
  endtask

  task automatic t_order;
    run_req("R9 type before low", 0, 8'd5, 8'd0, 0, 32'h0000_0001, 32'h0001_8000, 3'd1, 0, 0, 0);
    run_req("R9 low before align", 0, 8'd1, 8'd0, 0, 32'h0001_0000, 32'h0001_8000, 3'd2, 0, 0, 0);
    run_req("R9 align before range", 0, 8'd2, 8'd0, 0, 32'h0201_0000, 32'h0002_0000, 3'd3, 0, 0, 0);
  endtask

  task automatic t_query;
    run_req("R8 query ok", 1, 8'd2, 8'd0, 0, 32'h1, 32'h3, 3'd0, 0, 0, MEM_SZ);
    run_req("R8 query flash", 1, 8'd1, 8'd0, 0, 0, 0, 3'd1, 0, 0, 0);
    run_req("R8 query id1", 1, 8'd2, 8'd1, 0, 0, 0, 3'd1, 0, 0, 0);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    drive(0, 8'd1, 8'd0, 0, 0, 32'h0001_0000);
    @(negedge clk);
    check("R10 busy", 32'(busy_o), 1);
    drive(0, 8'd9, 8'd0, 0, 0, 32'h0001_8000);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R10 first done", 32'(done_o), 1);
    check("R10 first err", 32'(err_o), 0);
    check("R10 first w0", word0_o, 32'h2000_0000);
    @(negedge clk);
    check("R10 ignored no done", 32'(done_o), 0);
    check("R10 ignored no busy", 32'(busy_o), 0);
    @(negedge clk);
    check("R10 still idle", 32'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_pass();
    t_reject();
    t_order();
    t_query();
    t_busy_ignore();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule